// File: doc/BRIEF.md
# Edge-Triggered DMA Request Burst Generator

This block is one channel of a DMA request generator. It watches a single line picked out of a vector of trigger inputs. When that line shows a qualifying edge, the channel raises a DMA request. It keeps the request high until the DMA side reports it served, then raises the next one. It stops after a programmed number of requests. Each burst is `burst_len + 1` requests long.

The trigger line passes through a stability filter before any edge counts. Trigger events are blanked for a short window around every configuration write. An edge that arrives while a burst is still running sets a sticky overrun flag. That flag can raise an interrupt when the interrupt enable is set, and a write-one strobe clears it.

Top module: `trig_burst_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after that edge, `req`, `ovr_flag` and `ovr_irq` are 0.
- R2: `edge_mode` sets which edges of the filtered trigger count. 2'b00 means no edge counts and no requests are made. 2'b01 selects rising edges, 2'b10 falling edges and 2'b11 both.
- R3: A qualifying event with `gen_en` high starts a burst of exactly `burst_len + 1` requests; the count is loaded from `burst_len` at the start of each burst. `req` stays high until a rising edge sees `req` and `served` both high. It is low after that edge and, when requests remain, high again one edge later.
- R4: A new trigger level counts as an edge only after 3 consecutive rising edges sample it; shorter pulses are dropped. Suppose the level is first sampled at edge E0 and then held. `req` is still low after E3 and first high after E4.
- R5: The trigger line used is `trig_in[trig_sel]`; activity on every other bit of `trig_in` has no effect.
- R6: An event that qualifies at an edge where `cfg_wr` is high is discarded, and so is one at any of the 3 edges that follow.
- R7: A qualifying event with `gen_en` high while a burst is active sets `ovr_flag`; the running burst continues and still ends after its original count.
- R8: `ovr_flag` stays set until an edge with `ovr_clr` high clears it. If a set and a clear fall at the same edge, the set wins.
- R9: At each edge `ovr_irq` takes the new value of `ovr_flag` ANDed with `ovr_irq_en`.
- R10: When `gen_en` is low, `req` is low after the next edge and any running burst is abandoned; events seen while low start nothing and set no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | N_TRIG | Trigger input vector |
| trig_sel | input | SEL_W | Index of the watched trigger bit |
| edge_mode | input | 2 | Edge selection (none/rise/fall/both) |
| burst_len | input | CNT_W | Requests per burst minus one |
| gen_en | input | 1 | Channel enable |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| cfg_wr | input | 1 | Configuration write strobe, starts blanking |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| served | input | 1 | DMA side has served the current request |
| req | output | 1 | DMA request line |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The hardest case to reach from the ports is the collision of an overrun set and a clear write in one cycle. It is reached by holding `ovr_clr` high across a whole overlapping trigger. The bench then watches for the single cycle in which the flag must show. The blanking window is also delicate, because the filter delay exceeds the window. The bench issues the configuration write two edges after the trigger level changes, so the filtered edge lands inside the mask. Overruns are forced by leaving requests unserved while a second, opposite edge arrives under the both-edges mode.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  function automatic logic edge_hit(edge_mode_e m, logic r, logic f);
    return (r && (m == EDGE_RISE || m == EDGE_BOTH)) ||
           (f && (m == EDGE_FALL || m == EDGE_BOTH));
  endfunction

endpackage

// File: rtl/tbg_trig_filter.sv
module tbg_trig_filter #(
  parameter int N_TRIG     = 32,
  parameter int SEL_W      = $clog2(N_TRIG),
  parameter int STABLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              rise_p,
  output logic              fall_p
);
  localparam int RUN_W = $clog2(STABLE_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_CYC);

  logic             raw;
  logic             cand;
  logic             lvl;
  logic [RUN_W-1:0] run;

  assign raw = trig_in[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cand   <= 1'b0;
      lvl    <= 1'b0;
      run    <= RUN_MAX;
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (run == RUN_MAX && cand != lvl) begin
        lvl    <= cand;
        rise_p <= cand;
        fall_p <= ~cand;
      end
      if (raw != cand) begin
        cand <= raw;
        run  <= RUN_W'(1);
      end else if (run != RUN_MAX) begin
        run <= run + RUN_W'(1);
      end
    end
  end

endmodule

// File: rtl/tbg_blank_mask.sv
module tbg_blank_mask #(
  parameter int BLANK_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  output logic masked
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cfg_wr)      cnt <= BW'(BLANK_CYC);
    else if (cnt != '0)   cnt <= cnt - BW'(1);
  end

  assign masked = cfg_wr || (cnt != '0);

endmodule

// File: rtl/tbg_burst_core.sv
module tbg_burst_core #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ev,
  input  logic             served,
  input  logic [CNT_W-1:0] burst_len,
  output logic             req,
  output logic             ovr_set
);
  logic             active;
  logic [CNT_W-1:0] left;

  assign ovr_set = en && ev && active;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      req    <= 1'b0;
      left   <= '0;
    end else if (!active) begin
      if (ev) begin
        active <= 1'b1;
        req    <= 1'b1;
        left   <= burst_len;
      end
    end else if (req && served) begin
      req <= 1'b0;
      if (left == '0) active <= 1'b0;
      else            left   <= left - CNT_W'(1);
    end else if (!req) begin
      req <= 1'b1;
    end
  end

endmodule

// File: rtl/trig_burst_gen.sv
module trig_burst_gen #(
  parameter int N_TRIG     = 32,
  parameter int SEL_W      = $clog2(N_TRIG),
  parameter int CNT_W      = 5,
  parameter int STABLE_CYC = 3,
  parameter int BLANK_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [1:0]        edge_mode,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic              gen_en,
  input  logic              ovr_irq_en,
  input  logic              cfg_wr,
  input  logic              ovr_clr,
  input  logic              served,
  output logic              req,
  output logic              ovr_flag,
  output logic              ovr_irq
);
  import tbg_pkg::*;

  logic rise_p, fall_p, masked, ev, ovr_set, flag_nxt;

  tbg_trig_filter #(.N_TRIG(N_TRIG), .SEL_W(SEL_W), .STABLE_CYC(STABLE_CYC)) u_filt (
    .clk(clk), .rst(rst), .trig_in(trig_in), .sel(trig_sel),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  tbg_blank_mask #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .masked(masked)
  );

  assign ev = edge_hit(edge_mode_e'(edge_mode), rise_p, fall_p) && !masked;

  tbg_burst_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(gen_en), .ev(ev), .served(served),
    .burst_len(burst_len), .req(req), .ovr_set(ovr_set)
  );

  assign flag_nxt = ovr_set || (ovr_flag && !ovr_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
      ovr_irq  <= 1'b0;
    end else begin
      ovr_flag <= flag_nxt;
      ovr_irq  <= flag_nxt && ovr_irq_en;
    end
  end

endmodule

// File: rtl/tbg_checker.sv
module tbg_checker (
  input logic clk,
  input logic rst,
  input logic served,
  input logic gen_en,
  input logic ovr_clr,
  input logic ovr_irq_en,
  input logic req,
  input logic ovr_flag,
  input logic ovr_irq
);
  AST_REQ_HELD:     assert property (@(posedge clk) disable iff (rst) req && !served && gen_en |=> req);        // R3
  AST_SERVE_DROP:   assert property (@(posedge clk) disable iff (rst) req && served |=> !req);                  // R3
  AST_FLAG_STICKY:  assert property (@(posedge clk) disable iff (rst) ovr_flag && !ovr_clr |=> ovr_flag);       // R8
  AST_IRQ_GATED:    assert property (@(posedge clk) disable iff (rst) ovr_irq |-> $past(ovr_irq_en));           // R9
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst) ovr_irq |-> ovr_flag);                    // R9
  AST_DIS_NO_REQ:   assert property (@(posedge clk) disable iff (rst) !gen_en |=> !req);                        // R10
  AST_DIS_NO_OVR:   assert property (@(posedge clk) disable iff (rst) !gen_en && !ovr_flag |=> !ovr_flag);      // R10
endmodule

bind trig_burst_gen tbg_checker u_chk (
  .clk(clk), .rst(rst), .served(served), .gen_en(gen_en), .ovr_clr(ovr_clr),
  .ovr_irq_en(ovr_irq_en), .req(req), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
);

// File: tb/sim_trig_burst_gen.sv
module sim_trig_burst_gen;
  localparam int CLK_P  = 10;
  localparam int N_TRIG = 32;
  localparam int SEL_W  = 5;
  localparam int CNT_W  = 5;

  typedef struct packed {
    logic [1:0]       mode;
    logic [CNT_W-1:0] len;
    logic [SEL_W-1:0] sel;
    logic             lvl;
    logic [5:0]       exp;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'b01, 5'd0,  5'd0,  1'b1, 6'd1},
    '{2'b01, 5'd2,  5'd3,  1'b0, 6'd0},
    '{2'b10, 5'd3,  5'd6,  1'b1, 6'd0},
    '{2'b10, 5'd3,  5'd9,  1'b0, 6'd4},
    '{2'b11, 5'd1,  5'd12, 1'b1, 6'd2},
    '{2'b11, 5'd4,  5'd15, 1'b0, 6'd5},
    '{2'b00, 5'd2,  5'd18, 1'b1, 6'd0},
    '{2'b00, 5'd2,  5'd21, 1'b0, 6'd0},
    '{2'b01, 5'd31, 5'd31, 1'b1, 6'd32},
    '{2'b11, 5'd0,  5'd1,  1'b0, 6'd1}
  };

  logic clk = 0, rst = 1;
  logic [N_TRIG-1:0] trig_in = '0;
  logic [SEL_W-1:0]  trig_sel = '0;
  logic [1:0]        edge_mode = 2'b00;
  logic [CNT_W-1:0]  burst_len = '0;
  logic gen_en = 1, ovr_irq_en = 0, cfg_wr = 0, ovr_clr = 0, served = 0;
  logic req, ovr_flag, ovr_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  trig_burst_gen u0 (
    .clk(clk), .rst(rst), .trig_in(trig_in), .trig_sel(trig_sel),
    .edge_mode(edge_mode), .burst_len(burst_len), .gen_en(gen_en),
    .ovr_irq_en(ovr_irq_en), .cfg_wr(cfg_wr), .ovr_clr(ovr_clr),
    .served(served), .req(req), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] m, logic [CNT_W-1:0] l, logic [SEL_W-1:0] s);
    @(negedge clk);
    edge_mode = m; burst_len = l; trig_sel = s; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic count_reqs(int cyc, output int n);
    logic prev;
    n = 0; prev = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (req && !prev) n++;
      prev   = req;
      served = req;
    end
    @(negedge clk);
    served = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    check("R1 req in reset", req, 0);
    check("R1 ovr_flag in reset", ovr_flag, 0);
    check("R1 ovr_irq in reset", ovr_irq, 0);
    rst = 0;
    @(negedge clk);
    check("R1 req after reset", req, 0);

    // table walk: R2 edge modes, R3 burst lengths
    foreach (VEC[i]) begin
      cfg(VEC[i].mode, VEC[i].len, VEC[i].sel);
      trig_in = {N_TRIG{VEC[i].lvl}};
      count_reqs(120, n);
      check($sformatf("R2 R3 vector %0d count", i), n, int'(VEC[i].exp));
      check($sformatf("R3 vector %0d no overrun", i), ovr_flag, 0);
    end

    // R4 exact latency (level now 0)
    cfg(2'b01, 5'd0, 5'd4);
    trig_in = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 req low after E3", req, 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 req high after E4", req, 1);
    count_reqs(20, n);
    trig_in = '0;
    count_reqs(20, n);

    // R4 two-cycle glitch dropped, three-cycle pulse kept
    cfg(2'b11, 5'd0, 5'd2);
    trig_in = '1; repeat (2) @(negedge clk); trig_in = '0;
    count_reqs(30, n);
    check("R4 two-cycle glitch ignored", n, 0);
    cfg(2'b01, 5'd0, 5'd2);
    trig_in = '1; repeat (3) @(negedge clk); trig_in = '0;
    count_reqs(30, n);
    check("R4 three-cycle pulse accepted", n, 1);

    // R5 only the selected bit matters
    cfg(2'b11, 5'd0, 5'd7);
    trig_in = ~(32'd1 << 7);
    count_reqs(30, n);
    check("R5 unselected bits ignored", n, 0);
    trig_in = '1;
    count_reqs(30, n);
    check("R5 selected bit triggers", n, 1);
    trig_in = '0;
    count_reqs(30, n);

    // R6 blanking after a configuration write (level 0, rising mode)
    cfg(2'b01, 5'd0, 5'd0);
    trig_in = '1;
    @(negedge clk);
    @(negedge clk); cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    count_reqs(30, n);
    check("R6 edge inside blank window dropped", n, 0);
    trig_in = '0;
    count_reqs(20, n);

    // R7 overrun, R9 interrupt
    ovr_irq_en = 1;
    cfg(2'b11, 5'd5, 5'd0);
    trig_in = '1;
    repeat (8) @(negedge clk);
    check("R3 request held unserved", req, 1);
    trig_in = '0;
    repeat (8) @(negedge clk);
    check("R7 overrun flag set", ovr_flag, 1);
    check("R9 interrupt raised", ovr_irq, 1);
    count_reqs(60, n);
    check("R7 burst keeps original count", n, 6);
    pulse_clr();
    @(negedge clk);
    check("R8 flag cleared", ovr_flag, 0);
    check("R9 interrupt cleared", ovr_irq, 0);

    // R9 interrupt gated off
    ovr_irq_en = 0;
    trig_in = '1; repeat (8) @(negedge clk);
    trig_in = '0; repeat (8) @(negedge clk);
    check("R7 flag set again", ovr_flag, 1);
    check("R9 interrupt masked", ovr_irq, 0);
    count_reqs(60, n);
    pulse_clr();

    // R8 set wins over simultaneous clear
    ovr_clr = 1;
    trig_in = '1; repeat (8) @(negedge clk);
    trig_in = '0;
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (ovr_flag) seen = 1;
    end
    ovr_clr = 0;
    check("R8 set beats clear", int'(seen), 1);
    count_reqs(60, n);
    pulse_clr();

    // R10 disable aborts burst and ignores events
    trig_in = '1; repeat (8) @(negedge clk);
    check("R10 burst running before disable", req, 1);
    gen_en = 0;
    @(negedge clk);
    check("R10 req low after disable", req, 0);
    trig_in = '0; repeat (8) @(negedge clk);
    check("R10 no overrun while disabled", ovr_flag, 0);
    check("R10 no request while disabled", req, 0);
    gen_en = 1;
    count_reqs(30, n);
    check("R10 aborted burst does not resume", n, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule